// File: doc/BRIEF.md
# Guarded Countdown Watchdog with Periodic Tick Timers

This block pairs a small bank of programmable tick timers with a watchdog counter. Every timer counts pulses of a free-running 1 MHz clock-enable input, which the block receives from outside. Each time a timer's reload count runs out, it raises a one-cycle tick. The watchdog chooses one timer as its time source and counts four of that timer's ticks as one period unit. It counts down a programmed number of units. If software does not restart it in time, it raises a one-cycle reset request. Software controls everything through a plain word-addressed register port: write strobe, address and data, plus a separate combinational read address and read data.

Software arms the watchdog with a start command and keeps it alive by writing the same command again. Two writes are needed to stop it: a key value to the unlock word, then the disable command. A single stray write therefore cannot silence the watchdog. Clock-enable generation and the system reset logic that acts on the request are outside this block.

Top module: `gtick_wdt_top`

## Requirements
- R1: After reset every register reads as zero, all tick outputs are low, `reset_req` is low and the watchdog is idle.
- R2: A timer word holds enable in bit 31, auto-reload in bit 30 and the reload count N in bits [RELOAD_W-1:0]. While enabled, it expires on every Nth cycle with `us_en` high (N of 0 acts as 1). Its tick output is high for exactly the one cycle after the `us_en` cycle in which it expired.
- R3: When a timer expires with auto-reload set, it restarts from N. Without auto-reload it clears its own enable bit (bit 31 reads back 0) and raises no further ticks. Writing zero to a timer word stops that timer.
- R4: Address map in bytes: watchdog configuration 0x0, status 0x4, command 0x8, unlock 0xC, and timer i at 0x10+4*i. The command and unlock words read as zero. Configuration reads back source select in [3:0], period in [11:4] and reset-request enable in bit 15.
- R5: Writing command bit 0 loads the count from the configured period, clears the sub-count of ticks and sets the running state. It does this whether or not the watchdog is already running.
- R6: While running, only ticks from the selected timer advance the watchdog, and every fourth such tick ends one period unit. Status reads the count in bits [11:4] and the running state in bit 0.
- R7: At the end of a unit, a count of 2 or more decrements by one. A count of 1 or 0 reloads from the period instead, and if configuration bit 15 is set, `reset_req` goes high for exactly the one cycle after the cycle in which the fourth tick was high.
- R8: Command bit 1 stops the watchdog (running cleared, count kept) only if the last write to the unlock word was 0x0000C45A and no command write has come since. Otherwise it is ignored. When it takes effect in the same write as bit 0, the stop wins.
- R9: An unlock write of any other value clears the unlock state, and any command write also clears it.
- R10: Before the first start command, or after a stop, ticks change neither the count nor `reset_req`.
- R11: A source select value of NUM_TIMERS or more connects no timer, so the count does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_en | input | 1 | 1 MHz time-base enable, one cycle high per microsecond |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the combinational read |
| rd_data | output | 32 | Read data for `rd_addr` |
| tick | output | NUM_TIMERS | Per-timer expiry pulse |
| reset_req | output | 1 | One-cycle reset request on watchdog expiry |

## Verification
The bench measures the exact cycle of `reset_req` for several reload and period pairs. This catches a design that counts one tick per unit instead of four, or that fires one unit early or late. It re-arms the watchdog partway through a unit to show that the sub-count is cleared as well as the count; a design that left the sub-count alone would fire too early. It tries to disable the watchdog with no unlock, with the unlock used up by a start command, and with the key overwritten by a wrong value. A design whose unlock lingered would stop in each of these cases. It also covers a one-shot timer that must clear its own enable, an out-of-range source select that must freeze the count, and an expiry with the reset enable clear, which must reload the count and stay silent.

// File: rtl/gtick_pkg.sv
// gtick_pkg: shared field positions, register word indices and types for
// the tick timer and watchdog block. Assumes 32-bit word-aligned registers.
package gtick_pkg;
    localparam int TMR_EN_BIT   = 31;
    localparam int TMR_AUTO_BIT = 30;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_STOP_BIT  = 1;

    localparam int CFG_RSTEN_BIT = 15;
    localparam int PERIOD_W      = 8;
    localparam int SRC_W         = 4;

    localparam logic [31:0] UNLOCK_KEY = 32'h0000_C45A;

    // word indices (byte address / 4)
    localparam int W_CFG     = 0;
    localparam int W_STAT    = 1;
    localparam int W_CMD     = 2;
    localparam int W_UNLOCK  = 3;
    localparam int W_TMRBASE = 4;

    typedef struct packed {
        logic                rst_en;
        logic [PERIOD_W-1:0] period;
        logic [SRC_W-1:0]    src;
    } wd_cfg_t;
endpackage

// File: rtl/gtick_timer.sv
// gtick_timer: one programmable countdown timer clocked by the 1 MHz enable.
// Assumes us_en is a single-cycle strobe; a write to the timer word reloads
// the counter and suppresses any expiry in the same cycle.
module gtick_timer
    import gtick_pkg::*;
#(
    parameter int RELOAD_W = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        us_en,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] ctl_q,
    output logic        tick
);
    logic                en_q;
    logic                auto_q;
    logic [RELOAD_W-1:0] reload_q;
    logic [RELOAD_W-1:0] cnt_q;
    logic                expire;

    // expiry when the running count is at its last step
    assign expire = en_q && us_en && (cnt_q <= RELOAD_W'(1));

    // register write, countdown, reload or self-disable, tick pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            auto_q   <= 1'b0;
            reload_q <= '0;
            cnt_q    <= '0;
            tick     <= 1'b0;
        end else if (we) begin
            en_q     <= wdata[TMR_EN_BIT];
            auto_q   <= wdata[TMR_AUTO_BIT];
            reload_q <= wdata[RELOAD_W-1:0];
            cnt_q    <= wdata[RELOAD_W-1:0];
            tick     <= 1'b0;
        end else begin
            tick <= expire;
            if (expire) begin
                if (auto_q) cnt_q <= reload_q;
                else        en_q  <= 1'b0;
            end else if (en_q && us_en) begin
                cnt_q <= cnt_q - RELOAD_W'(1);
            end
        end
    end

    // readback image of the timer word
    always_comb begin
        ctl_q               = '0;
        ctl_q[TMR_EN_BIT]   = en_q;
        ctl_q[TMR_AUTO_BIT] = auto_q;
        ctl_q[RELOAD_W-1:0] = reload_q;
    end
endmodule

// File: rtl/gtick_wdog.sv
// gtick_wdog: watchdog period counter with start, guarded stop and unlock
// key. Assumes the strobes are mutually exclusive (one register per write)
// and src_tick pulses last one cycle.
module gtick_wdog
    import gtick_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cmd_we,
    input  logic                unlock_we,
    input  logic [31:0]         wdata,
    input  logic [NUM_SRC-1:0]  src_tick,
    output wd_cfg_t             cfg_q,
    output logic [PERIOD_W-1:0] count_q,
    output logic                running_q,
    output logic                unlocked_q,
    output logic                reset_req
);
    logic [1:0] sub_q;
    logic       sel_tick;
    logic       start_cmd;
    logic       stop_cmd;

    // pick the tick of the configured source; out-of-range picks none
    always_comb begin
        sel_tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cfg_q.src == SRC_W'(i)) sel_tick = src_tick[i];
        end
    end

    assign start_cmd = cmd_we && wdata[CMD_START_BIT];
    assign stop_cmd  = cmd_we && wdata[CMD_STOP_BIT] && unlocked_q;

    // configuration register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q.src    <= wdata[SRC_W-1:0];
            cfg_q.period <= wdata[SRC_W +: PERIOD_W];
            cfg_q.rst_en <= wdata[CFG_RSTEN_BIT];
        end
    end

    // unlock key state: set by the key, cleared by other values or any command
    always_ff @(posedge clk) begin
        if (!rst_n)         unlocked_q <= 1'b0;
        else if (cmd_we)    unlocked_q <= 1'b0;
        else if (unlock_we) unlocked_q <= (wdata == UNLOCK_KEY);
    end

    // run state, sub-count of ticks, period count and reset request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            count_q   <= '0;
            sub_q     <= '0;
            reset_req <= 1'b0;
        end else begin
            reset_req <= 1'b0;
            if (start_cmd || stop_cmd) begin
                if (start_cmd) begin
                    count_q <= cfg_q.period;
                    sub_q   <= '0;
                end
                running_q <= !stop_cmd;
            end else if (running_q && sel_tick) begin
                sub_q <= sub_q + 2'd1;
                if (sub_q == 2'd3) begin
                    if (count_q <= PERIOD_W'(1)) begin
                        count_q   <= cfg_q.period;
                        reset_req <= cfg_q.rst_en;
                    end else begin
                        count_q <= count_q - PERIOD_W'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/gtick_wdt_top.sv
// gtick_wdt_top: register decode, timer bank and watchdog. Assumes ADDR_W is
// wide enough for word index W_TMRBASE+NUM_TIMERS-1; reads are combinational.
module gtick_wdt_top
    import gtick_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    parameter int RELOAD_W   = 24,
    parameter int ADDR_W     = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  us_en,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [31:0]           wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [31:0]           rd_data,
    output logic [NUM_TIMERS-1:0] tick,
    output logic                  reset_req
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0]   wr_word;
    logic [WORD_W-1:0]   rd_word;
    logic                wd_cfg_we;
    logic                wd_cmd_we;
    logic                wd_unlock_we;
    wd_cfg_t             wd_cfg;
    logic [PERIOD_W-1:0] wd_count;
    logic                wd_running;
    logic                wd_unlocked;
    logic [31:0]         tmr_ctl [NUM_TIMERS];

    assign wr_word = wr_addr[ADDR_W-1:2];
    assign rd_word = rd_addr[ADDR_W-1:2];

    assign wd_cfg_we    = wr_en && (wr_word == WORD_W'(W_CFG));
    assign wd_cmd_we    = wr_en && (wr_word == WORD_W'(W_CMD));
    assign wd_unlock_we = wr_en && (wr_word == WORD_W'(W_UNLOCK));

    // one timer per generate slot, each at its own word
    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
        logic tmr_we;
        assign tmr_we = wr_en && (wr_word == WORD_W'(W_TMRBASE + t));
        gtick_timer #(.RELOAD_W(RELOAD_W)) tmr_i (
            .clk   (clk),
            .rst_n (rst_n),
            .us_en (us_en),
            .we    (tmr_we),
            .wdata (wr_data),
            .ctl_q (tmr_ctl[t]),
            .tick  (tick[t])
        );
    end

    gtick_wdog #(.NUM_SRC(NUM_TIMERS)) wdog_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (wd_cfg_we),
        .cmd_we     (wd_cmd_we),
        .unlock_we  (wd_unlock_we),
        .wdata      (wr_data),
        .src_tick   (tick),
        .cfg_q      (wd_cfg),
        .count_q    (wd_count),
        .running_q  (wd_running),
        .unlocked_q (wd_unlocked),
        .reset_req  (reset_req)
    );

    // read mux over watchdog words and timer words
    always_comb begin
        rd_data = '0;
        if (rd_word == WORD_W'(W_CFG)) begin
            rd_data[SRC_W-1:0]           = wd_cfg.src;
            rd_data[SRC_W +: PERIOD_W]   = wd_cfg.period;
            rd_data[CFG_RSTEN_BIT]       = wd_cfg.rst_en;
        end else if (rd_word == WORD_W'(W_STAT)) begin
            rd_data[0]                   = wd_running;
            rd_data[SRC_W +: PERIOD_W]   = wd_count;
        end else begin
            for (int i = 0; i < NUM_TIMERS; i++) begin
                if (rd_word == WORD_W'(W_TMRBASE + i)) rd_data = tmr_ctl[i];
            end
        end
    end
endmodule

// File: rtl/gtick_wdt_chk.sv
// gtick_wdt_chk: property checker bound to gtick_wdt_top. Observes ports and
// the watchdog state nets; drives nothing.
module gtick_wdt_chk #(
    parameter int NUM_TIMERS = 2,
    parameter int PERIOD_W   = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  us_en,
    input logic [NUM_TIMERS-1:0] tick,
    input logic                  reset_req,
    input logic                  running,
    input logic                  unlocked,
    input logic                  rst_en,
    input logic [PERIOD_W-1:0]   count,
    input logic                  cmd_we,
    input logic [31:0]           wr_data
);
    // R2: a tick only follows a cycle with the time-base enable high
    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tk
        assert_tick_after_us_R2: assert property (@(posedge clk) disable iff (!rst_n)
            tick[t] |-> $past(us_en));
    end

    // R7: the reset request lasts one cycle
    assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R7: a request needs a running watchdog with the enable bit set
    assert_req_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> ($past(running) && $past(rst_en)));

    // R8: a stop command without unlock leaves the watchdog running
    assert_stop_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && wr_data[1] && !unlocked && running) |=> running);

    // R9: any command write consumes the unlock state
    assert_unlock_spent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> !unlocked);

    // R10: while idle and not started the count does not move
    assert_idle_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(cmd_we && wr_data[0])) |=> $stable(count));
endmodule

bind gtick_wdt_top gtick_wdt_chk #(.NUM_TIMERS(NUM_TIMERS), .PERIOD_W(8)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .us_en     (us_en),
    .tick      (tick),
    .reset_req (reset_req),
    .running   (wd_running),
    .unlocked  (wd_unlocked),
    .rst_en    (wd_cfg.rst_en),
    .count     (wd_count),
    .cmd_we    (wd_cmd_we),
    .wr_data   (wr_data)
);

// File: tb/gtick_wdt_top_tb.sv
module gtick_wdt_top_tb_top;
    localparam int NT = 2;
    localparam int AW = 6;

    localparam logic [AW-1:0] A_CFG  = 6'h00;
    localparam logic [AW-1:0] A_STAT = 6'h04;
    localparam logic [AW-1:0] A_CMD  = 6'h08;
    localparam logic [AW-1:0] A_UNL  = 6'h0C;
    localparam logic [AW-1:0] A_T0   = 6'h10;
    localparam logic [AW-1:0] A_T1   = 6'h14;

    localparam logic [31:0] T_EN   = 32'h8000_0000;
    localparam logic [31:0] T_AUTO = 32'h4000_0000;
    localparam logic [31:0] RSTEN  = 32'h0000_8000;
    localparam logic [31:0] KEY    = 32'h0000_C45A;

    // vector table: reload, period, expected cycles from timer write to request
    localparam int NV = 5;
    localparam int VEC [NV][3] = '{
        '{2, 1, 9}, '{3, 2, 25}, '{1, 3, 13}, '{5, 0, 21}, '{4, 4, 65}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          us_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NT-1:0] tick;
    logic          reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gtick_wdt_top #(.NUM_TIMERS(NT), .RELOAD_W(24), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .us_en(us_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .tick(tick), .reset_req(reset_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    // one time-base pulse; reports tick after it and request one cycle later
    task automatic pulse(output logic [NT-1:0] tk, output logic rq);
        @(negedge clk);
        us_en = 1'b1;
        @(negedge clk);
        us_en = 1'b0;
        tk = tick;
        @(negedge clk);
        rq = reset_req;
    endtask

    task automatic pulses(input int n, output int rq_count);
        logic [NT-1:0] tk;
        logic rq;
        rq_count = 0;
        for (int k = 0; k < n; k++) begin
            pulse(tk, rq);
            if (rq) rq_count++;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [NT-1:0] tk;
        logic rq;
        int n;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_CFG, v);  chk("R1 cfg", v, 32'h0);
        rd(A_STAT, v); chk("R1 status", v, 32'h0);
        rd(A_T0, v);   chk("R1 timer0", v, 32'h0);
        chk("R1 outputs", {30'h0, tick}, 32'h0);
        chk("R1 reset_req", {31'h0, reset_req}, 32'h0);

        // R4: configuration readback, command and unlock read as zero
        wr(A_CFG, RSTEN | 32'h0000_0A51);
        rd(A_CFG, v); chk("R4 cfg readback", v, 32'h0000_8A51);
        wr(A_UNL, KEY);
        rd(A_UNL, v); chk("R4 unlock reads zero", v, 32'h0);
        rd(A_CMD, v); chk("R4 command reads zero", v, 32'h0);

        // R10: not started, ticks do nothing
        wr(A_CFG, RSTEN | (32'd1 << 4));
        wr(A_T0, T_EN | T_AUTO | 32'd1);
        pulses(8, n);
        chk("R10 no request before start", n, 0);
        rd(A_STAT, v); chk("R10 idle status", v, 32'h0);

        // R7 R2: vector table with free-running time base
        for (int i = 0; i < NV; i++) begin
            wr(A_T0, 32'h0);
            wr(A_CFG, RSTEN | (32'(VEC[i][1]) << 4));
            wr(A_CMD, 32'h1);
            @(negedge clk);
            us_en = 1'b1;
            wr(A_T0, T_EN | T_AUTO | 32'(VEC[i][0]));
            n = 0;
            while (!reset_req && n < 400) begin
                @(negedge clk);
                n++;
            end
            chk($sformatf("R7 vector %0d request cycle", i), n, VEC[i][2]);
            @(negedge clk);
            chk($sformatf("R7 vector %0d single pulse", i), {31'h0, reset_req}, 32'h0);
            us_en = 1'b0;
        end
        wr(A_T0, 32'h0);

        // R5 R6: restart mid-unit clears count and sub-count
        wr(A_CFG, RSTEN | (32'd2 << 4));
        wr(A_T0, T_EN | T_AUTO | 32'd1);
        wr(A_CMD, 32'h1);
        pulses(5, n);
        chk("R6 no early request", n, 0);
        rd(A_STAT, v); chk("R6 status after five ticks", v, 32'h11);
        wr(A_CMD, 32'h1);
        rd(A_STAT, v); chk("R5 restart reloads", v, 32'h21);
        pulses(7, n);
        chk("R5 no request within seven ticks", n, 0);
        pulse(tk, rq);
        chk("R7 request on eighth tick", {31'h0, rq}, 32'h1);

        // R7: expiry with reset enable clear reloads silently
        wr(A_CFG, 32'd1 << 4);
        wr(A_CMD, 32'h1);
        pulses(4, n);
        chk("R7 no request when disabled", n, 0);
        rd(A_STAT, v); chk("R7 reload when disabled", v, 32'h11);

        // R8: stop without unlock ignored
        wr(A_CFG, RSTEN | (32'd3 << 4));
        wr(A_CMD, 32'h1);
        wr(A_CMD, 32'h2);
        rd(A_STAT, v); chk("R8 stop ignored without key", v, 32'h31);
        // R9: unlock consumed by a start command
        wr(A_UNL, KEY);
        wr(A_CMD, 32'h1);
        wr(A_CMD, 32'h2);
        rd(A_STAT, v); chk("R9 key consumed by command", v, 32'h31);
        // R9: wrong value clears the key
        wr(A_UNL, KEY);
        wr(A_UNL, 32'h0000_1234);
        wr(A_CMD, 32'h2);
        rd(A_STAT, v); chk("R9 wrong value clears key", v, 32'h31);
        // R8: proper unlock then stop
        wr(A_UNL, KEY);
        wr(A_CMD, 32'h2);
        rd(A_STAT, v); chk("R8 stop with key", v, 32'h30);
        // R10: stopped watchdog ignores ticks
        pulses(12, n);
        chk("R10 no request after stop", n, 0);
        rd(A_STAT, v); chk("R10 count frozen after stop", v, 32'h30);

        // R11: unconnected and unselected sources
        wr(A_CFG, RSTEN | (32'd1 << 4) | 32'd1);
        wr(A_CMD, 32'h1);
        pulses(4, n);
        chk("R11 other timer ignored", n, 0);
        wr(A_CFG, RSTEN | (32'd1 << 4) | 32'd5);
        wr(A_CMD, 32'h1);
        pulses(4, n);
        chk("R11 out-of-range source", n, 0);
        rd(A_STAT, v); chk("R11 count unchanged", v, 32'h11);
        wr(A_T1, T_EN | T_AUTO | 32'd1);
        wr(A_CFG, RSTEN | (32'd1 << 4) | 32'd1);
        wr(A_CMD, 32'h1);
        pulses(4, n);
        chk("R11 timer1 as source", n, 1);
        wr(A_T1, 32'h0);

        // R3: one-shot clears enable; zero write stops
        wr(A_T0, T_EN | 32'd1);
        pulse(tk, rq);
        chk("R3 one-shot tick", {30'h0, tk}, 32'h1);
        rd(A_T0, v); chk("R3 one-shot enable cleared", v, 32'h1);
        pulse(tk, rq);
        chk("R3 no second one-shot tick", {30'h0, tk}, 32'h0);
        wr(A_T0, T_EN | T_AUTO | 32'd3);
        wr(A_T0, 32'h0);
        rd(A_T0, v); chk("R3 zero write readback", v, 32'h0);
        pulses(4, n);
        pulse(tk, rq);
        chk("R3 stopped timer no tick", {30'h0, tk}, 32'h0);

        // R2: tick lasts exactly one cycle
        wr(A_T0, T_EN | T_AUTO | 32'd1);
        pulse(tk, rq);
        chk("R2 tick after us_en", {30'h0, tk}, 32'h1);
        chk("R2 tick one cycle", {30'h0, tick}, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule